// File: doc/BRIEF.md
# Answer-FIFO Write Strobe and Capture Pulse Generator

This block turns slow or software-driven control events into clean pulses one clock tick wide. Its main output writes one word into an answer FIFO. That write pulse can come from one of two sources, chosen by a select bit:

- **External strobe.** The strobe is long and asynchronous, and its data lines settle before it rises. The block synchronizes it and fires the pulse on its trailing edge. This gives the FIFO data the most setup time.
- **Software bit.** Software writes the bit 0 then 1 then 0. The block fires the pulse on the 0-to-1 transition.

The same rising-edge mechanism gives software an immediate capture-monitor request. That pulse is ORed with the capture strobe from the cycle sequencer, and the result drives a second pulse output of the same one-tick width.

The external strobe is about 430 ns long. It therefore covers several ticks of the sampling clock. A strobe that is sampled high for fewer than a set number of ticks is treated as a glitch and dropped. Changing the source select clears the edge history. This stops a strobe or bit that is already active from producing a spurious write.

Top module: `ans_wr_pulse_gen`

## Requirements
- R1: When `src_sw_sel` is 1, only the software bit `sw_wr_bit` can produce `wr_pulse`. When it is 0, only `ext_ans_strobe` can produce `wr_pulse`. Activity on the unselected source never shows on `wr_pulse`.
- R2: The external strobe passes through a 2-stage synchronizer. Take the first clock edge that samples the strobe low after a valid high period. `wr_pulse` is high for exactly one cycle, just after the second clock edge that follows that edge.
- R3: A strobe sampled high at fewer than MIN_HIGH_TICKS consecutive clock edges (default 2) gives no write pulse. A strobe of any longer length gives exactly one write pulse.
- R4: With the software source selected, a 0-to-1 change of `sw_wr_bit` sampled at a clock edge drives `wr_pulse` high for the one cycle after that edge.
- R5: A software bit held at 1 gives no further pulses until it has been sampled at 0 and then rises again. This applies to both `sw_wr_bit` and `imm_cap_bit`.
- R6: A 0-to-1 change of `imm_cap_bit` sampled at a clock edge drives `cap_pulse` high for the one cycle after that edge. This works whatever the source select is.
- R7: `seq_cap_strobe` sampled high at a clock edge drives `cap_pulse` high for the cycle after that edge. It is ORed with the pulse from R6.
- R8: Call a clock edge where `src_sw_sel` differs from its value at the previous edge a change edge.
  - `wr_pulse` stays low in the cycle after a change edge.
  - An external strobe seen high at the synchronizer output at or after a change edge gives no pulse. This lasts until the synchronizer output has been seen low again.
- R9: While `rst_n` is low, `wr_pulse` and `cap_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one cycle is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ans_strobe | input | 1 | Long asynchronous answer strobe; the write fires on its falling edge |
| src_sw_sel | input | 1 | Write source select: 1 = software bit, 0 = external strobe |
| sw_wr_bit | input | 1 | Software write bit; a rising edge requests one write pulse |
| imm_cap_bit | input | 1 | Software immediate-capture bit; a rising edge requests one capture pulse |
| seq_cap_strobe | input | 1 | One-tick capture strobe from the cycle sequencer |
| wr_pulse | output | 1 | One-tick answer FIFO write pulse |
| cap_pulse | output | 1 | One-tick capture-monitor pulse |

## Verification
The assertions check, on every cycle:
- that the write pulse never lasts two cycles;
- that each source is locked out while the other is selected;
- that a software rise always produces a pulse, and a held bit never does;
- that a select change is followed by a quiet cycle;
- that the capture pulse follows both of its sources.

Some behaviours depend on the history of the asynchronous strobe, so only the bench scenarios can show them:
- the two-edge delay from the trailing edge to the pulse;
- the glitch filter, which drops one-tick strobes and keeps two-tick ones;
- a strobe that spans a select change producing no write at all.

These scenarios are compared every cycle against a behavioural model and with pulse counts.

// File: rtl/awp_pkg.sv
package awp_pkg;

    // State of a rising-edge pulse unit
    typedef struct packed {
        logic prev;   // input value seen at the previous edge
        logic pulse;  // registered one-tick output
    } rise_st_t;

    // State held at the top level
    typedef struct packed {
        logic sel;    // source select seen at the previous edge
        logic seq;    // registered sequencer capture strobe
    } top_st_t;

    localparam int unsigned N_RISE = 2;  // software-driven rising-edge units
    localparam int unsigned RISE_IMM = 0;
    localparam int unsigned RISE_SW  = 1;

endpackage

// File: rtl/awp_sync.sv
module awp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] ch_d, ch_q;

    always_comb ch_d[0] = async_i;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_comb ch_d[g] = ch_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign sync_o = ch_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs two stages");
    end
endmodule

// File: rtl/awp_fall_det.sv
module awp_fall_det #(
    parameter int unsigned MIN_HIGH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,    // synchronized strobe
    input  logic en_i,     // this source is selected
    input  logic clr_i,    // select changed at this edge
    output logic pulse_o
);
    localparam int unsigned CW = $clog2(MIN_HIGH + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(MIN_HIGH);

    typedef struct packed {
        logic          prev;
        logic          blk;   // strobe was high across a select change
        logic [CW-1:0] run;   // saturating count of high ticks
        logic          pulse;
    } fall_st_t;

    fall_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = en_i & ~clr_i & st_q.prev & ~lvl_i & (st_q.run >= RUN_MAX);
        if (clr_i) begin
            st_d.prev = 1'b0;
            st_d.blk  = 1'b1;
            st_d.run  = '0;
        end else begin
            st_d.prev = lvl_i;
            st_d.blk  = lvl_i ? st_q.blk : 1'b0;
            if (!lvl_i)
                st_d.run = '0;
            else if (!st_q.blk && st_q.run != RUN_MAX)
                st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // A trailing edge can only produce a single tick
    assert_ext_one_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // A pulse needs the strobe to have been high at the previous edge
    assert_ext_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_i && !$past(lvl_i)) |=> !pulse_o);
endmodule

// File: rtl/awp_rise_pulse.sv
module awp_rise_pulse
    import awp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pulse_o
);
    rise_st_t st_d, st_q;

    always_comb begin
        st_d.prev  = bit_i;
        st_d.pulse = en_i & ~clr_i & bit_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    // A bit held high gives no repeat pulse
    assert_rise_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_i && $past(bit_i)) |=> !pulse_o);
endmodule

// File: rtl/ans_wr_pulse_gen.sv
module ans_wr_pulse_gen
    import awp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned MIN_HIGH_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ans_strobe,
    input  logic src_sw_sel,
    input  logic sw_wr_bit,
    input  logic imm_cap_bit,
    input  logic seq_cap_strobe,
    output logic wr_pulse,
    output logic cap_pulse
);
    top_st_t st_d, st_q;
    logic    sel_chg;
    logic    ext_lvl;
    logic    ext_pulse;
    logic [N_RISE-1:0] r_bit, r_en, r_clr, r_pulse;

    always_comb begin
        st_d.sel = src_sw_sel;
        st_d.seq = seq_cap_strobe;
        sel_chg  = src_sw_sel ^ st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    awp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(ext_ans_strobe),
        .sync_o (ext_lvl)
    );

    awp_fall_det #(.MIN_HIGH(MIN_HIGH_TICKS)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ext_lvl),
        .en_i   (~src_sw_sel),
        .clr_i  (sel_chg),
        .pulse_o(ext_pulse)
    );

    always_comb begin
        r_bit[RISE_IMM] = imm_cap_bit;
        r_en [RISE_IMM] = 1'b1;
        r_clr[RISE_IMM] = 1'b0;
        r_bit[RISE_SW]  = sw_wr_bit;
        r_en [RISE_SW]  = src_sw_sel;
        r_clr[RISE_SW]  = sel_chg;
    end

    genvar g;
    generate
        for (g = 0; g < N_RISE; g++) begin : g_rise
            awp_rise_pulse u_rise (
                .clk    (clk),
                .rst_n  (rst_n),
                .bit_i  (r_bit[g]),
                .en_i   (r_en[g]),
                .clr_i  (r_clr[g]),
                .pulse_o(r_pulse[g])
            );
        end
    endgenerate

    assign wr_pulse  = ext_pulse | r_pulse[RISE_SW];
    assign cap_pulse = r_pulse[RISE_IMM] | st_q.seq;

    // Each source is locked out while the other is selected
    assert_ext_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        src_sw_sel |=> !ext_pulse);
    assert_sw_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !src_sw_sel |=> !r_pulse[RISE_SW]);

    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    assert_sw_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sw_sel && $past(src_sw_sel) && sw_wr_bit && !$past(sw_wr_bit)) |=> wr_pulse);

    assert_sw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sw_sel && $past(src_sw_sel) && sw_wr_bit && $past(sw_wr_bit)) |=> !wr_pulse);

    assert_imm_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_cap_bit && !$past(imm_cap_bit)) |=> cap_pulse);

    assert_seq_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_cap_strobe |=> cap_pulse);

    assert_sel_chg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sw_sel != $past(src_sw_sel)) |=> !wr_pulse);

    always @(posedge clk) begin
        assert_reset_quiet_R9: assert (rst_n || (!wr_pulse && !cap_pulse));
    end
endmodule

// File: tb/sim_ans_wr_pulse_gen.sv
module sim_ans_wr_pulse_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_ans_strobe = 1'b0;
    logic src_sw_sel = 1'b0;
    logic sw_wr_bit = 1'b0;
    logic imm_cap_bit = 1'b0;
    logic seq_cap_strobe = 1'b0;
    logic wr_pulse, cap_pulse;

    always #2 clk = ~clk;  // 250 MHz

    ans_wr_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .ext_ans_strobe(ext_ans_strobe),
        .src_sw_sel(src_sw_sel), .sw_wr_bit(sw_wr_bit), .imm_cap_bit(imm_cap_bit),
        .seq_cap_strobe(seq_cap_strobe), .wr_pulse(wr_pulse), .cap_pulse(cap_pulse)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R9";
    int wr_seen = 0;
    int cap_seen = 0;

    // Behavioural reference: strobe delay queue plus edge bookkeeping
    bit ext_q[$];
    int m_run = 0;
    bit m_prev = 0, m_blk = 0, m_sel = 0, m_sw = 0, m_imm = 0;
    bit exp_wr = 0, exp_cap = 0;
    localparam int MIN_HIGH = 2;

    task automatic model_step();
        bit s, chg, ep, sp;
        if (!rst_n) begin
            ext_q = '{0, 0};
            m_run = 0; m_prev = 0; m_blk = 0; m_sel = 0; m_sw = 0; m_imm = 0;
            exp_wr = 0; exp_cap = 0;
            return;
        end
        s   = ext_q[0];
        chg = (src_sw_sel != m_sel);
        ep  = !src_sw_sel && !chg && m_prev && !s && (m_run >= MIN_HIGH);
        sp  = src_sw_sel && !chg && sw_wr_bit && !m_sw;
        if (chg) begin
            m_prev = 0; m_blk = 1; m_run = 0;
        end else begin
            m_prev = s;
            if (!s) begin m_blk = 0; m_run = 0; end
            else if (!m_blk) m_run = m_run + 1;
        end
        void'(ext_q.pop_front());
        ext_q.push_back(ext_ans_strobe);
        exp_wr  = ep | sp;
        exp_cap = (imm_cap_bit && !m_imm) | seq_cap_strobe;
        m_sw  = sw_wr_bit;
        m_imm = imm_cap_bit;
        m_sel = src_sw_sel;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(wr_pulse === exp_wr, cur_req, "wr_pulse", wr_pulse, exp_wr);
        chk(cap_pulse === exp_cap, cur_req, "cap_pulse", cap_pulse, exp_cap);
        if (wr_pulse === 1'b1) wr_seen++;
        if (cap_pulse === 1'b1) cap_seen++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic strobe(int len);
        ext_ans_strobe = 1'b1;
        idle(len);
        ext_ans_strobe = 1'b0;
        idle(8);
    endtask

    initial begin
        idle(3);
        cur_req = "R9";
        chk(wr_pulse === 1'b0 && cap_pulse === 1'b0, "R9", "reset outputs", wr_pulse, 0);
        rst_n = 1'b1;
        idle(3);

        // R2: long strobe, exactly one write pulse
        cur_req = "R2"; wr_seen = 0;
        strobe(4);
        chk(wr_seen == 1, "R2", "pulses for 4-tick strobe", wr_seen, 1);

        // R3: glitch filter and minimum length
        cur_req = "R3"; wr_seen = 0;
        strobe(1);
        chk(wr_seen == 0, "R3", "pulses for 1-tick strobe", wr_seen, 0);
        wr_seen = 0;
        strobe(2);
        chk(wr_seen == 1, "R3", "pulses for 2-tick strobe", wr_seen, 1);
        wr_seen = 0;
        strobe(12);
        chk(wr_seen == 1, "R3", "pulses for 12-tick strobe", wr_seen, 1);

        // R1: strobe ignored with the software source selected
        cur_req = "R1"; src_sw_sel = 1'b1; idle(3); wr_seen = 0;
        strobe(5);
        chk(wr_seen == 0, "R1", "ext pulses under sw select", wr_seen, 0);

        // R4: software 0-1-0
        cur_req = "R4"; wr_seen = 0;
        sw_wr_bit = 1'b1; idle(1); sw_wr_bit = 1'b0; idle(3);
        chk(wr_seen == 1, "R4", "pulses for sw 0-1-0", wr_seen, 1);

        // R5: held software bit
        cur_req = "R5"; wr_seen = 0;
        sw_wr_bit = 1'b1; idle(10);
        chk(wr_seen == 1, "R5", "pulses for held sw bit", wr_seen, 1);
        sw_wr_bit = 1'b0; idle(2);

        // R1: software bit ignored with the external source selected
        cur_req = "R1"; src_sw_sel = 1'b0; idle(3); wr_seen = 0;
        sw_wr_bit = 1'b1; idle(2); sw_wr_bit = 1'b0; idle(3);
        chk(wr_seen == 0, "R1", "sw pulses under ext select", wr_seen, 0);

        // R6: immediate capture, including a held bit
        cur_req = "R6"; cap_seen = 0;
        imm_cap_bit = 1'b1; idle(1); imm_cap_bit = 1'b0; idle(3);
        chk(cap_seen == 1, "R6", "cap pulses for imm 0-1-0", cap_seen, 1);
        cap_seen = 0;
        imm_cap_bit = 1'b1; idle(8); imm_cap_bit = 1'b0; idle(2);
        chk(cap_seen == 1, "R6", "cap pulses for held imm", cap_seen, 1);

        // R7: sequencer strobe, alone and together with imm
        cur_req = "R7"; cap_seen = 0;
        seq_cap_strobe = 1'b1; idle(1); seq_cap_strobe = 1'b0; idle(3);
        chk(cap_seen == 1, "R7", "cap pulses for seq strobe", cap_seen, 1);
        cap_seen = 0;
        seq_cap_strobe = 1'b1; imm_cap_bit = 1'b1; idle(1);
        seq_cap_strobe = 1'b0; imm_cap_bit = 1'b0; idle(3);
        chk(cap_seen == 1, "R7", "cap pulses for seq with imm", cap_seen, 1);

        // R8: strobe spanning two select changes
        cur_req = "R8"; wr_seen = 0;
        ext_ans_strobe = 1'b1; idle(3);
        src_sw_sel = 1'b1; idle(2);
        src_sw_sel = 1'b0; idle(3);
        ext_ans_strobe = 1'b0; idle(8);
        chk(wr_seen == 0, "R8", "pulses for strobe across change", wr_seen, 0);

        // R8: sw bit rising on the change edge, then held
        wr_seen = 0;
        src_sw_sel = 1'b1; sw_wr_bit = 1'b1; idle(6);
        chk(wr_seen == 0, "R8", "pulses for rise on change edge", wr_seen, 0);
        sw_wr_bit = 1'b0; idle(2);

        // R2: normal strobe after returning to the external source
        cur_req = "R2"; src_sw_sel = 1'b0; idle(3); wr_seen = 0;
        strobe(3);
        chk(wr_seen == 1, "R2", "pulses after reselect", wr_seen, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule